// File: doc/BRIEF.md
# Banked cartridge ROM mapper

This block sits between a CPU with a 16-bit address bus and a large external ROM organised as 16 KiB banks. The lowest 16 KiB of CPU address space always shows the first bank of the ROM. The next 16 KiB is a switchable window. The bank shown there is chosen by control registers that the CPU loads by writing into the ROM's own address range. Those writes never reach the ROM.

The switchable bank number has two parts. A 5-bit low field forms bank bits 4..0. A 2-bit high field forms bank bits 6..5, but only while the mode bit is clear. The ROM address is formed as the bank number concatenated with the 14-bit offset inside the window. It is then cut to the configured ROM address width, so a bank beyond the end of a smaller ROM wraps around. The mapping is combinational from the address bus. A register write takes effect from the clock edge that captures it.

Top module: `rom_bank_mapper`

## Requirements
- R1: A CPU address 0x0000..0x3FFF maps to a ROM address equal to its low 14 bits, with all bank bits zero, whatever the register contents are.
- R2: A CPU address 0x4000..0x7FFF maps to ROM address bank*0x4000 + (address - 0x4000), that is {bank, address[13:0]}.
- R3: A write (wr_i high at a rising clock edge) to 0x2000..0x3FFF loads wdata_i[4:0] into the low bank field. wdata_i[7:5] are ignored.
- R4: A write of 0 in bits 4..0 to the low bank field stores 1, so the switchable window never shows bank 0 through the low field alone.
- R5: A write to 0x4000..0x5FFF loads wdata_i[1:0] into the high bank field. A write to 0x6000..0x7FFF loads wdata_i[0] into the mode bit.
- R6: With mode 0 the bank is {high, low}, with the high field at bit 5. With mode 1 the bank equals the low field and the high field has no effect.
- R7: rom_addr_o is ROM_AW bits wide (default 20, 64 banks). Bank bits at position ROM_AW-14 and above are dropped, so an out-of-range bank wraps.
- R8: After reset the low field is 1, the high field is 0 and the mode is 0, so the switchable window shows bank 1.
- R9: Writes to 0x0000..0x1FFF or to 0x8000..0xFFFF, and cycles with wr_i low, leave the bank selection unchanged.
- R10: rom_rd_o is high exactly when rd_i is high and the address is below 0x8000, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data for the control registers |
| rom_addr_o | output | ROM_AW | Mapped ROM byte address |
| rom_rd_o | output | 1 | ROM read enable |

## Verification
The hardest state to reach from the ports is a bank number whose top bit lies outside the configured ROM while the high field is either included or suppressed. Reaching it takes three ordered writes: a nonzero high field, a chosen low field, and then the mode bit toggled both ways. The bench reads the switchable window after each write to show the wrap and the suppression. It also reaches the substitution of 0 by 1 through a write with nonzero upper data bits over a zero low part, which checks the stored value and the ignored bits together.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int unsigned OFS_W  = 14;  // 16 KiB bank
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = 2;
  localparam int unsigned BANK_W = LO_W + HI_W;

  // decode of addr[15:13] for writes
  typedef enum logic [2:0] {
    SEL_NONE = 3'b000,
    SEL_LO   = 3'b001,
    SEL_HI   = 3'b010,
    SEL_MODE = 3'b011
  } wsel_e;

  typedef struct packed {
    logic [LO_W-1:0] lo;
    logic [HI_W-1:0] hi;
    logic            mode;
  } bank_cfg_t;
endpackage

// File: rtl/rbm_ctrl_regs.sv
module rbm_ctrl_regs
  import rbm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       sel_i,
  input  logic [LO_W-1:0]  wdata_i,
  output bank_cfg_t        cfg_o
);
  bank_cfg_t cfg_q, cfg_d;
  wsel_e     sel;

  assign sel = wsel_e'(sel_i);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      unique case (sel)
        SEL_LO:   cfg_d.lo   = (wdata_i == '0) ? LO_W'(1) : wdata_i;
        SEL_HI:   cfg_d.hi   = wdata_i[HI_W-1:0];
        SEL_MODE: cfg_d.mode = wdata_i[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.lo   <= LO_W'(1);
      cfg_q.hi   <= '0;
      cfg_q.mode <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R3
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'b001 && wdata_i != '0) |=> cfg_q.lo == $past(wdata_i));
  // R4
  lo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'b001 && wdata_i == '0) |=> cfg_q.lo == LO_W'(1));
  // R5
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'b010) |=> cfg_q.hi == $past(wdata_i[HI_W-1:0]));
  // R5
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'b011) |=> cfg_q.mode == $past(wdata_i[0]));
  // R9
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sel_i[2] && sel_i[1:0] != 2'b00) |=> $stable(cfg_q));
endmodule

// File: rtl/rbm_bank_sel.sv
module rbm_bank_sel
  import rbm_pkg::*;
(
  input  bank_cfg_t         cfg_i,
  output logic [BANK_W-1:0] bank_o
);
  // high field joins at bit LO_W only in mode 0
  always_comb begin
    bank_o = {HI_W'(0), cfg_i.lo};
    if (!cfg_i.mode) bank_o[BANK_W-1:LO_W] = cfg_i.hi;
  end
endmodule

// File: rtl/rbm_addr_map.sv
module rbm_addr_map
  import rbm_pkg::*;
#(
  parameter int unsigned ROM_AW = 20
) (
  input  logic [14:0]       addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int unsigned FULL_W = BANK_W + OFS_W;

  logic [BANK_W-1:0] bank_eff;
  logic [FULL_W-1:0] full_addr;

  assign bank_eff  = addr_i[OFS_W] ? bank_i : '0;
  assign full_addr = {bank_eff, addr_i[OFS_W-1:0]};

  generate
    if (ROM_AW >= FULL_W) begin : g_wide
      assign rom_addr_o = ROM_AW'(full_addr);
    end else begin : g_wrap
      // power-of-two ROM: drop bank bits beyond its size
      assign rom_addr_o = full_addr[ROM_AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rbm_pkg::*;
#(
  parameter int unsigned ROM_AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_rd_o
);
  localparam int unsigned BANK_OUT_W = ROM_AW - OFS_W;

  bank_cfg_t         cfg;
  logic [BANK_W-1:0] bank;
  logic [2:0]        unused_wdata;

  assign unused_wdata = wdata_i[7:LO_W];

  rbm_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .sel_i   (addr_i[15:13]),
    .wdata_i (wdata_i[LO_W-1:0]),
    .cfg_o   (cfg)
  );

  rbm_bank_sel u_bank (
    .cfg_i  (cfg),
    .bank_o (bank)
  );

  rbm_addr_map #(.ROM_AW(ROM_AW)) u_map (
    .addr_i     (addr_i[14:0]),
    .bank_i     (bank),
    .rom_addr_o (rom_addr_o)
  );

  assign rom_rd_o = rd_i & ~addr_i[15];

  // R1
  low_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> rom_addr_o == ROM_AW'(addr_i[13:0]));
  // R6
  mode1_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b01 && cfg.mode) |->
      rom_addr_o[ROM_AW-1:OFS_W] == BANK_OUT_W'(cfg.lo));
  // R2
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> rom_addr_o[OFS_W-1:0] == addr_i[OFS_W-1:0]);
  // R10
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[15] |-> !rom_rd_o);
endmodule

// File: tb/rom_bank_mapper_tb_top.sv
module rom_bank_mapper_tb_top;
  localparam int unsigned AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   addr_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [AW-1:0] rom_addr_o;
  logic          rom_rd_o;

  int total = 0;
  int bad = 0;

  // bench model of the selection registers
  logic [4:0] m_lo = 5'd1;
  logic [1:0] m_hi = 2'd0;
  logic       m_mode = 1'b0;

  always #5 clk_i = ~clk_i;

  rom_bank_mapper #(.ROM_AW(AW)) dut_i (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i, .rom_addr_o, .rom_rd_o
  );

  function automatic logic [AW-1:0] exp_addr(input logic [15:0] a);
    logic [6:0]  b;
    logic [20:0] full;
    b = m_mode ? {2'b00, m_lo} : {m_hi, m_lo};
    if (!a[14]) b = '0;
    full = {b, a[13:0]};
    return full[AW-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b0;
    if (a[15:13] == 3'b001) m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
    else if (a[15:13] == 3'b010) m_hi = d[1:0];
    else if (a[15:13] == 3'b011) m_mode = d[0];
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1;
    chk(req, 32'(rom_addr_o), 32'(exp_addr(a)));
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R8", 16'h4000);
    chk("R8", 32'(rom_addr_o), 32'h0_4000);
    rd_chk("R8", 16'h7FFF);
  endtask

  task automatic t_lower();
    wr(16'h2000, 8'h13);
    wr(16'h4000, 8'h03);
    rd_chk("R1", 16'h0000);
    rd_chk("R1", 16'h3FFF);
    rd_chk("R1", 16'h1A5C);
    chk("R1", 32'(rom_addr_o), 32'h1A5C);
  endtask

  task automatic t_low_field();
    wr(16'h4000, 8'h00);
    wr(16'h2ABC, 8'hE7);      // upper data bits ignored -> 0x07
    rd_chk("R3", 16'h4123);
    chk("R3", 32'(rom_addr_o), 32'h1_C123);
    wr(16'h3FFF, 8'h1F);
    rd_chk("R2", 16'h7FFF);
    chk("R2", 32'(rom_addr_o), 32'h7_FFFF);
  endtask

  task automatic t_zero_low();
    wr(16'h2000, 8'h00);
    rd_chk("R4", 16'h4000);
    chk("R4", 32'(rom_addr_o), 32'h0_4000);
    wr(16'h2000, 8'hE0);
    rd_chk("R4", 16'h5555);
    chk("R4", 32'(rom_addr_o), 32'h0_5555);
  endtask

  task automatic t_mode_high();
    wr(16'h2000, 8'h05);
    wr(16'h5FFF, 8'h01);
    rd_chk("R6", 16'h4010);
    chk("R6", 32'(rom_addr_o), 32'h9_4010);   // bank 0x25
    wr(16'h6000, 8'h01);
    rd_chk("R6", 16'h4010);
    chk("R6", 32'(rom_addr_o), 32'h1_4010);   // bank 5
    wr(16'h7FFF, 8'hFE);                      // bit0 = 0 -> mode 0
    rd_chk("R5", 16'h4010);
    chk("R5", 32'(rom_addr_o), 32'h9_4010);
  endtask

  task automatic t_wrap();
    wr(16'h4000, 8'h02);                      // bank 0x45 -> wraps to 0x05
    rd_chk("R7", 16'h4321);
    chk("R7", 32'(rom_addr_o), 32'h1_4321);
    wr(16'h4000, 8'h03);                      // bank 0x65 -> 0x25
    rd_chk("R7", 16'h4321);
    chk("R7", 32'(rom_addr_o), 32'h9_4321);
  endtask

  task automatic t_ignored();
    wr(16'h0000, 8'h0A);
    wr(16'h1FFF, 8'h1A);
    wr(16'hA000, 8'h0B);
    wr(16'hE000, 8'h01);
    @(negedge clk_i);
    addr_i = 16'h2000; wdata_i = 8'h09; wr_i = 1'b0;
    @(negedge clk_i);
    rd_chk("R9", 16'h4444);
    chk("R9", 32'(rom_addr_o), 32'h9_4444);
  endtask

  task automatic t_rd();
    @(negedge clk_i);
    addr_i = 16'h7FFF; rd_i = 1'b1; #1;
    chk("R10", 32'(rom_rd_o), 32'd1);
    addr_i = 16'h8000; #1;
    chk("R10", 32'(rom_rd_o), 32'd0);
    addr_i = 16'h0000; rd_i = 1'b0; #1;
    chk("R10", 32'(rom_rd_o), 32'd0);
    rd_i = 1'b1; #1;
    chk("R10", 32'(rom_rd_o), 32'd1);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lower();
    t_low_field();
    t_zero_low();
    t_mode_high();
    t_wrap();
    t_ignored();
    t_rd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule